// File: doc/BRIEF.md
# Framed Serial Transmit Engine with Sync-Error Handling

This block turns parallel words into a framed serial bit stream. Software-side logic writes a word into a one-entry holding buffer. A frame pulse starts a word: it moves the buffered word into a shift register and then sends it MSB first on `tx_dout`, one bit for each `bit_tick` enable. Two status outputs describe the buffer: `buf_ready` (the buffer is free) and the active-low `sr_empty_n` (the stream has run out of fresh data).

Each accepted frame pulse (`fsync` high in a `bit_tick` cycle) is handled according to the state of the engine. The state machine has three states: `ST_IDLE` (no word on the line), `ST_SHIFT` (a word is being sent and more bits follow the current one) and `ST_LAST` (the final bit is on the line).

- `ST_IDLE` → `ST_SHIFT` on a pulse: a new word starts.
- `ST_SHIFT` → `ST_LAST` on the tick that puts the final bit out.
- `ST_SHIFT` → `ST_SHIFT` on an unexpected pulse. What follows depends on `frame_ignore`. When it is set, the pulse is treated as a plain tick. When it is clear, the word is aborted, `sync_err` is set and the same word is sent again from its MSB.
- `ST_LAST` → `ST_SHIFT` on a pulse: the next word starts back to back.
- `ST_LAST` → `ST_IDLE` on a tick without a pulse: the word ends.

When `tx_en` is low, the whole engine is held at its reset values.

Top module: `fstx_engine`

## Requirements
- R1: While `tx_en` is low the engine ignores writes and frame pulses. Dropping `tx_en` returns every output to its reset value on the next clock: `tx_dout`=0, `buf_ready`=1, `sr_empty_n`=0 and `sync_err`=0.
- R2: A frame pulse in `ST_IDLE` or `ST_LAST` starts a word. The word's MSB is on `tx_dout` after that clock edge. The following ticks present the remaining bits, so back-to-back words leave no gap.
- R3: With `frame_ignore`=1, a frame pulse in `ST_SHIFT` has no effect: the next bit goes out and `sync_err` does not change.
- R4: With `frame_ignore`=0, a frame pulse in `ST_SHIFT` sets `sync_err` and puts the MSB of the current word back on `tx_dout`. The whole word then follows again.
- R5: A write clears `buf_ready` at the next edge. A word start that consumes the buffered word sets `buf_ready`. If a write and a start fall in the same cycle, the start uses the buffer's earlier state, and the newly written word stays buffered with `buf_ready`=0.
- R6: `sr_empty_n` goes low at the tick that ends a word if no unsent word is buffered. A write drives it high at the next edge. A write made before the next frame pulse is the word sent by that pulse.
- R7: Bits change only in `bit_tick` cycles. A `fsync` without `bit_tick` is ignored.
- R8: `sync_err` stays set until `err_clr` is pulsed or `tx_en` drops. If an abort and `err_clr` fall in the same cycle, the flag stays set.
- R9: A frame pulse that finds the buffer free sends the previous word again (all zeros after reset) and leaves `sr_empty_n` low.
- R10: `tx_dout` is 0 whenever the engine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low holds the engine in reset |
| frame_ignore | input | 1 | 1: unexpected frame pulses are ignored |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | WORD_W | Word to buffer |
| bit_tick | input | 1 | One-cycle transmit bit enable |
| fsync | input | 1 | Frame pulse, qualified by `bit_tick` |
| err_clr | input | 1 | Clears `sync_err` |
| tx_dout | output | 1 | Serial data, MSB first |
| buf_ready | output | 1 | Holding buffer is free |
| sr_empty_n | output | 1 | Low when the stream has no fresh data |
| sync_err | output | 1 | Sticky unexpected-frame error |

## Verification
Two pairs of events can land in the same cycle. The first is a buffer write in the cycle where a frame pulse starts a word. The bench provokes it with an empty buffer and checks three things: the earlier word is sent again, `buf_ready` reads 0 afterwards, and the new word goes out on the next frame. The second is an abort together with `err_clr`; the bench checks that `sync_err` reads 1 afterwards. The bench also sweeps the abort and ignore positions across every mid-word bit, and checks each serial bit against the written word.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LAST  = 2'd2
    } fstx_state_t;
endpackage

// File: rtl/fstx_fsm.sv
module fstx_fsm
    import fstx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_tick,
    input  logic fsync,
    input  logic frame_ignore,
    input  logic err_clr,
    output logic start,
    output logic restart,
    output logic shift,
    output logic finish,
    output logic to_idle,
    output logic busy,
    output logic sync_err
);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    fstx_state_t      st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             abort;
    logic             frame_hit;

    assign frame_hit = bit_tick && fsync;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= ST_IDLE;
        else if (!en) st <= ST_IDLE;
        else          st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (frame_hit) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (bit_tick && !(fsync && !frame_ignore) && cnt == CNT_ONE)
                    nxt = ST_LAST;
            end
            ST_LAST: begin
                if (bit_tick) nxt = fsync ? ST_SHIFT : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start   = 1'b0;
        restart = 1'b0;
        shift   = 1'b0;
        finish  = 1'b0;
        to_idle = 1'b0;
        abort   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                start = frame_hit;
            end
            ST_SHIFT: begin
                if (bit_tick) begin
                    if (fsync && !frame_ignore) begin
                        abort   = 1'b1;
                        restart = 1'b1;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            ST_LAST: begin
                if (bit_tick) begin
                    finish  = 1'b1;
                    start   = fsync;
                    to_idle = !fsync;
                end
            end
            default: ;
        endcase
        if (!en) begin
            start   = 1'b0;
            restart = 1'b0;
            shift   = 1'b0;
            finish  = 1'b0;
            to_idle = 1'b0;
            abort   = 1'b0;
        end
    end

    assign busy = (st != ST_IDLE);

    // bit counter: bits still to follow the one on the line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!en)              cnt <= '0;
        else if (start || restart) cnt <= CNT_FULL;
        else if (shift)            cnt <= cnt - CNT_ONE;
    end

    // sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sync_err <= 1'b0;
        else if (!en)     sync_err <= 1'b0;
        else if (abort)   sync_err <= 1'b1;
        else if (err_clr) sync_err <= 1'b0;
    end

    // R4
    abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (st == ST_SHIFT && bit_tick && fsync && !frame_ignore)
        |=> (sync_err && st == ST_SHIFT && cnt == CNT_FULL));

    // R3
    ignore_mid_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (st == ST_SHIFT && bit_tick && fsync && frame_ignore && !sync_err)
        |=> !sync_err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (sync_err && !err_clr) |=> sync_err);

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (!bit_tick) |=> $stable(st));
endmodule

// File: rtl/fstx_buffer.sv
module fstx_buffer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    input  logic              finish,
    output logic [WORD_W-1:0] buf_data,
    output logic              buf_full,
    output logic              buf_ready,
    output logic              empty_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_full <= 1'b0;
        end else if (!en) begin
            buf_data <= '0;
            buf_full <= 1'b0;
        end else if (wr_en) begin
            buf_data <= wr_data;
            buf_full <= 1'b1;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      empty_n <= 1'b0;
        else if (!en)                    empty_n <= 1'b0;
        else if (wr_en)                  empty_n <= 1'b1;
        else if (finish && !buf_full)    empty_n <= 1'b0;
    end

    assign buf_ready = !buf_full;

    // R5
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en) |=> !buf_ready);

    // R6
    wr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en) |=> empty_n);

    // R1
    hold_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (buf_ready && !empty_n));
endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              to_idle,
    input  logic              busy,
    output logic [WORD_W-1:0] cur_word,
    output logic              tx_dout
);
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg     <= '0;
            cur_word <= '0;
            tx_dout  <= 1'b0;
        end else if (!en) begin
            sreg     <= '0;
            cur_word <= '0;
            tx_dout  <= 1'b0;
        end else if (load) begin
            cur_word <= load_word;
            tx_dout  <= load_word[WORD_W-1];
            sreg     <= {load_word[WORD_W-2:0], 1'b0};
        end else if (shift) begin
            tx_dout  <= sreg[WORD_W-1];
            sreg     <= {sreg[WORD_W-2:0], 1'b0};
        end else if (to_idle) begin
            tx_dout  <= 1'b0;
            sreg     <= '0;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> !tx_dout);

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (!bit_tick) |=> $stable(tx_dout));
endmodule

// File: rtl/fstx_engine.sv
module fstx_engine
    import fstx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              frame_ignore,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic              err_clr,
    output logic              tx_dout,
    output logic              buf_ready,
    output logic              sr_empty_n,
    output logic              sync_err
);
    logic              start, restart, shift, finish, to_idle, busy;
    logic              buf_full;
    logic [WORD_W-1:0] buf_data, cur_word, load_word;

    fstx_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(tx_en),
        .bit_tick(bit_tick), .fsync(fsync),
        .frame_ignore(frame_ignore), .err_clr(err_clr),
        .start(start), .restart(restart), .shift(shift),
        .finish(finish), .to_idle(to_idle), .busy(busy),
        .sync_err(sync_err)
    );

    fstx_buffer #(.WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .en(tx_en),
        .wr_en(wr_en), .wr_data(wr_data),
        .take(start), .finish(finish),
        .buf_data(buf_data), .buf_full(buf_full),
        .buf_ready(buf_ready), .empty_n(sr_empty_n)
    );

    // fresh word on a start with data waiting, else the current word
    always_comb begin
        if (start && buf_full) load_word = buf_data;
        else                   load_word = cur_word;
    end

    fstx_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .bit_tick(bit_tick),
        .load(start || restart), .load_word(load_word),
        .shift(shift), .to_idle(to_idle), .busy(busy),
        .cur_word(cur_word), .tx_dout(tx_dout)
    );
endmodule

// File: tb/test_fstx_engine.sv
module test_fstx_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       frame_ignore = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic       fsync = 1'b0;
    logic       err_clr = 1'b0;
    logic       tx_dout, buf_ready, sr_empty_n, sync_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] w;
    logic [7:0] last_w;

    always #(CLK_PERIOD/2) clk = ~clk;

    fstx_engine #(.WORD_W(8)) i_fstx_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_ignore(frame_ignore),
        .wr_en(wr_en), .wr_data(wr_data), .bit_tick(bit_tick), .fsync(fsync),
        .err_clr(err_clr), .tx_dout(tx_dout), .buf_ready(buf_ready),
        .sr_empty_n(sr_empty_n), .sync_err(sync_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic f, input logic wr,
                       input logic [7:0] d, input logic c);
        bit_tick = t; fsync = f; wr_en = wr; wr_data = d; err_clr = c;
        @(negedge clk);
        bit_tick = 1'b0; fsync = 1'b0; wr_en = 1'b0; err_clr = 1'b0;
    endtask

    // bits 6..0 after the start cycle
    task automatic rest_of_word(input logic [7:0] v, input string tag);
        for (int i = 6; i >= 0; i--) begin
            cyc(1, 0, 0, 8'h00, 0);
            chk(tag, {7'd0, tx_dout}, {7'd0, v[i]});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1)
        chk("R1 dout", {7'd0, tx_dout}, 8'd0);
        chk("R1 ready", {7'd0, buf_ready}, 8'd1);
        chk("R1 empty_n", {7'd0, sr_empty_n}, 8'd0);
        chk("R1 err", {7'd0, sync_err}, 8'd0);

        // disabled: write and frame ignored (R1)
        cyc(1, 1, 1, 8'h77, 0);
        chk("R1 ready while disabled", {7'd0, buf_ready}, 8'd1);
        chk("R1 dout while disabled", {7'd0, tx_dout}, 8'd0);

        tx_en = 1'b1;
        @(negedge clk);

        // normal word (R2, R5, R6)
        cyc(0, 0, 1, 8'hA5, 0);
        chk("R5 ready after write", {7'd0, buf_ready}, 8'd0);
        chk("R6 empty_n after write", {7'd0, sr_empty_n}, 8'd1);
        // fsync with no tick is ignored (R7)
        cyc(0, 1, 0, 8'h00, 0);
        chk("R7 fsync no tick", {7'd0, tx_dout}, 8'd0);
        cyc(1, 1, 0, 8'h00, 0);
        chk("R2 msb", {7'd0, tx_dout}, 8'd1);
        chk("R5 ready after copy", {7'd0, buf_ready}, 8'd1);
        rest_of_word(8'hA5, "R2 bits");
        cyc(1, 0, 0, 8'h00, 0);
        chk("R10 idle low", {7'd0, tx_dout}, 8'd0);
        chk("R6 empty at end", {7'd0, sr_empty_n}, 8'd0);

        // back-to-back with prevention (R2, R6)
        cyc(0, 0, 1, 8'h3C, 0);
        cyc(1, 1, 0, 8'h00, 0);
        chk("R2 msb 3C", {7'd0, tx_dout}, 8'd0);
        for (int i = 6; i >= 0; i--) begin
            cyc(1, 0, (i == 3), 8'hC3, 0);
            chk("R2 bits 3C", {7'd0, tx_dout}, {7'd0, 8'h3C >> i} & 8'd1);
        end
        cyc(1, 1, 0, 8'h00, 0);
        chk("R6 next word msb", {7'd0, tx_dout}, 8'd1);
        chk("R6 no underflow", {7'd0, sr_empty_n}, 8'd1);
        rest_of_word(8'hC3, "R6 bits C3");

        // underflow repeats previous word (R9)
        cyc(1, 1, 0, 8'h00, 0);
        chk("R9 repeat msb", {7'd0, tx_dout}, 8'd1);
        chk("R9 empty_n low", {7'd0, sr_empty_n}, 8'd0);
        chk("R9 ready", {7'd0, buf_ready}, 8'd1);
        rest_of_word(8'hC3, "R9 bits");
        cyc(1, 0, 0, 8'h00, 0);
        chk("R10 idle after repeat", {7'd0, tx_dout}, 8'd0);

        // abort sweep over every mid-word position (R4, R8)
        frame_ignore = 1'b0;
        for (int p = 1; p < 8; p++) begin
            w = 8'(8'h5B + p * 29);
            cyc(0, 0, 1, w, 0);
            cyc(1, 1, 0, 8'h00, 0);
            chk("R2 sweep msb", {7'd0, tx_dout}, {7'd0, w[7]});
            for (int k = 1; k < p; k++) begin
                cyc(1, 0, 0, 8'h00, 0);
                chk("R4 pre-abort bit", {7'd0, tx_dout}, {7'd0, w[7-k]});
            end
            cyc(1, 1, 0, 8'h00, (p == 4));
            chk("R4 restart msb", {7'd0, tx_dout}, {7'd0, w[7]});
            chk("R4 err set", {7'd0, sync_err}, 8'd1);
            rest_of_word(w, "R4 restart bits");
            cyc(1, 0, 0, 8'h00, 0);
            chk("R8 err sticky", {7'd0, sync_err}, 8'd1);
            cyc(0, 0, 0, 8'h00, 1);
            chk("R8 err cleared", {7'd0, sync_err}, 8'd0);
            last_w = w;
        end

        // ignore sweep (R3)
        frame_ignore = 1'b1;
        for (int p = 1; p < 8; p++) begin
            w = 8'(8'h1D + p * 53);
            cyc(0, 0, 1, w, 0);
            cyc(1, 1, 0, 8'h00, 0);
            for (int k = 1; k < 8; k++) begin
                cyc(1, (k == p), 0, 8'h00, 0);
                chk("R3 bit continues", {7'd0, tx_dout}, {7'd0, w[7-k]});
            end
            chk("R3 no error", {7'd0, sync_err}, 8'd0);
            cyc(1, 0, 0, 8'h00, 0);
            last_w = w;
        end
        frame_ignore = 1'b0;

        // write in the same cycle as an underflow start (R5, R9)
        cyc(1, 1, 1, 8'h5A, 0);
        chk("R9 old word msb", {7'd0, tx_dout}, {7'd0, last_w[7]});
        chk("R5 ready after same-cycle write", {7'd0, buf_ready}, 8'd0);
        rest_of_word(last_w, "R9 old word bits");
        cyc(1, 1, 0, 8'h00, 0);
        chk("R5 buffered word msb", {7'd0, tx_dout}, 8'd0);
        chk("R5 ready after copy", {7'd0, buf_ready}, 8'd1);
        rest_of_word(8'h5A, "R5 buffered bits");
        cyc(1, 0, 0, 8'h00, 0);

        // sparse ticks (R7)
        cyc(0, 0, 1, 8'h96, 0);
        cyc(1, 1, 0, 8'h00, 0);
        for (int i = 6; i >= 0; i--) begin
            cyc(0, 1, 0, 8'h00, 0);
            chk("R7 hold", {7'd0, tx_dout}, {7'd0, 8'h96 >> (i + 1)} & 8'd1);
            cyc(0, 0, 0, 8'h00, 0);
            cyc(1, 0, 0, 8'h00, 0);
            chk("R7 bit", {7'd0, tx_dout}, {7'd0, 8'h96 >> i} & 8'd1);
        end
        cyc(1, 0, 0, 8'h00, 0);

        // enable drop mid-word (R1)
        cyc(0, 0, 1, 8'hFF, 0);
        cyc(1, 1, 0, 8'h00, 0);
        cyc(1, 0, 0, 8'h00, 0);
        cyc(1, 1, 0, 8'h00, 0);
        chk("R4 err before drop", {7'd0, sync_err}, 8'd1);
        cyc(0, 0, 1, 8'h11, 0);
        tx_en = 1'b0;
        cyc(1, 0, 0, 8'h00, 0);
        chk("R1 dout after drop", {7'd0, tx_dout}, 8'd0);
        chk("R1 err after drop", {7'd0, sync_err}, 8'd0);
        chk("R1 ready after drop", {7'd0, buf_ready}, 8'd1);
        chk("R1 empty_n after drop", {7'd0, sr_empty_n}, 8'd0);

        finish_run();
    end
endmodule